// File: doc/BRIEF.md
# Capture Register with Glitch Filter

This block records the value of an external free-running 16-bit count at the moment a chosen transition occurs on an asynchronous input line. The line is first brought into the clock domain through a two-stage synchronizer. An optional digital filter can then be switched on. The filter lets the level it reports change only after four consecutive samples agree. A transition detector watches the selected level, either filtered or raw synchronized. It fires on a rising or a falling transition, as chosen by a polarity input.

When a qualifying transition is seen, the block stores the count in a holding register and sets a sticky status bit. When the interrupt enable is high, that bit drives an interrupt line. Software, or a neighbouring block, clears the status bit with a one-cycle clear pulse. The counter itself lives outside this block and arrives as an input.

Top module: `capture_unit`

## Requirements
- R1: With the filter off, a pin transition present before clock edge k is detected at edge k+2. At that edge the holding register takes the count value present at edge k+2, and the status bit is visible after edge k+2 and not before.
- R2: With the filter on, the same detection happens at edge k+6, exactly four edges later than with the filter off.
- R3: With the filter on, a pin pulse that lasts 1 to 3 cycles and then returns produces no capture. With the filter off, a 1-cycle pulse is enough to capture.
- R4: A polarity input of 1 captures only on a low-to-high transition, and 0 only on a high-to-low transition. The opposite transition leaves the status bit and the holding register unchanged.
- R5: The holding register changes only on a capture, and it then holds the count value sampled at the capture edge.
- R6: The status bit is set by a capture and stays set until a clear pulse. A capture at the same edge as a clear leaves the bit set.
- R7: The interrupt line is high exactly when the status bit is set and the interrupt enable is high.
- R8: Changing the polarity input or the filter enable while the pin is steady does not by itself cause a capture.
- R9: During reset the holding register reads 0, and the status bit and the interrupt line read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 1 | Asynchronous capture line |
| count_val | input | 16 | Running count to be sampled |
| filt_en | input | 1 | 1 enables the four-sample filter |
| edge_rise | input | 1 | 1 selects rising transitions, 0 selects falling |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the status bit while high |
| cap_value | output | 16 | Holding register |
| cap_flag | output | 1 | Sticky capture status |
| cap_irq | output | 1 | Interrupt request |

## Verification
The hardest situation to bring about is a change of filter enable while the filtered and raw synchronized levels disagree. In that state a careless design would see a false transition. The stimulus reaches it with a directed sequence: a short pulse with the filter on, so that the raw level is high while the filtered level is still low, and then the filter switched off in the middle of the pulse. Random pin hold times of one to eight cycles push the filter across its four-sample boundary in both directions. Clears are mixed in at random, some of them landing on a capture edge.

// File: rtl/capture_unit.sv
module capture_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic [CNT_W-1:0] count_val,
  input  logic             filt_en,
  input  logic             edge_rise,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             cap_irq
);

  // stored filter history; the live synchronized sample makes the last one
  localparam int HIST_W = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_W-1:0]      hist_q;
  logic                   filt_q;
  logic                   lvl_q;
  logic                   fen_q;
  logic                   pin_s;
  logic                   lvl;
  logic                   all_hi;
  logic                   all_lo;
  logic                   trig;

  assign pin_s  = sync_q[SYNC_STAGES-1];
  assign all_hi = &{hist_q, pin_s};
  assign all_lo = ~|{hist_q, pin_s};
  assign lvl    = filt_en ? filt_q : pin_s;
  assign trig   = (filt_en == fen_q) && (lvl != lvl_q) && (lvl == edge_rise);
  assign cap_irq = cap_flag & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cap_pin};
      hist_q <= {hist_q[HIST_W-2:0], pin_s};
      if (all_hi)      filt_q <= 1'b1;
      else if (all_lo) filt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q     <= 1'b0;
      fen_q     <= 1'b0;
      cap_value <= '0;
      cap_flag  <= 1'b0;
    end else begin
      lvl_q <= lvl;
      fen_q <= filt_en;
      if (trig) cap_value <= count_val;
      cap_flag <= trig | (cap_flag & ~flag_clr);
    end
  end

endmodule

// File: rtl/capture_unit_chk.sv
module capture_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_en,
  input logic             flag_clr,
  input logic [CNT_W-1:0] cap_value,
  input logic             cap_flag,
  input logic             cap_irq
);

  // R5
  value_only_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_value) |-> cap_flag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);

  // R6
  flag_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_flag) |-> $past(flag_clr));

  // R7
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && irq_en) |-> cap_irq);

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> (cap_flag && irq_en));

endmodule

bind capture_unit capture_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .flag_clr(flag_clr),
  .cap_value(cap_value), .cap_flag(cap_flag), .cap_irq(cap_irq)
);

// File: tb/test_capture_unit.sv
module test_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_pin = 1'b0;
  logic [15:0] count_val = '0;
  logic        filt_en = 1'b0;
  logic        edge_rise = 1'b0;
  logic        irq_en = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag;
  logic        cap_irq;

  int checks = 0;
  int errors = 0;

  // bench-side reference state
  logic [5:0]  ph = '0;   // ph[j] = pin at edge n-j
  logic        mf = 1'b0, mdet = 1'b0, mfe = 1'b0, mflag = 1'b0;
  logic [15:0] mval = '0;
  logic [15:0] cnt = 16'h0100;
  logic        cur_pin = 1'b0, cur_er = 1'b0, cur_fe = 1'b0, cur_ie = 1'b0;

  capture_unit i_capture_unit (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .count_val(count_val),
    .filt_en(filt_en), .edge_rise(edge_rise), .irq_en(irq_en), .flag_clr(flag_clr),
    .cap_value(cap_value), .cap_flag(cap_flag), .cap_irq(cap_irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic next_filt(input logic [5:0] h, input logic f);
    if (h[5:2] == 4'hF) return 1'b1;
    if (h[5:2] == 4'h0) return 1'b0;
    return f;
  endfunction

  // called at a falling edge; drives inputs for the next rising edge, then checks
  task automatic step(input logic pin, input logic er, input logic fe, input logic ie, input logic clr);
    logic det_n, cap;
    cap_pin = pin; edge_rise = er; filt_en = fe; irq_en = ie; flag_clr = clr; count_val = cnt;
    cur_pin = pin; cur_er = er; cur_fe = fe; cur_ie = ie;
    ph = {ph[4:0], pin};
    det_n = fe ? mf : ph[2];
    cap = (fe == mfe) && (det_n != mdet) && (det_n == er);
    if (cap) mval = cnt;
    mflag = cap | (mflag & ~clr);
    mdet = det_n; mfe = fe; mf = next_filt(ph, mf);
    @(posedge clk); @(negedge clk);
    check(cap_value == mval, "R5", cap_value, mval);
    check(cap_flag == mflag, "R6", {15'd0, cap_flag}, {15'd0, mflag});
    check(cap_irq == (mflag & ie), "R7", {15'd0, cap_irq}, {15'd0, mflag & ie});
    cnt = cnt + 16'd3;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) step(cur_pin, cur_er, cur_fe, cur_ie, 1'b0);
  endtask

  task automatic clear_flag();
    step(cur_pin, cur_er, cur_fe, cur_ie, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(cap_value == 16'd0, "R9", cap_value, 16'd0);
    check(cap_flag == 1'b0, "R9", {15'd0, cap_flag}, 16'd0);
    check(cap_irq == 1'b0, "R9", {15'd0, cap_irq}, 16'd0);
    rst_n = 1'b1;

    // R1: unfiltered rising edge, two-edge latency
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0); hold(6); clear_flag();
    c0 = cnt;
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0); step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check(cap_flag == 1'b0, "R1 early", {15'd0, cap_flag}, 16'd0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check(cap_flag == 1'b1, "R1 flag", {15'd0, cap_flag}, 16'd1);
    check(cap_value == c0 + 16'd6, "R1 value", cap_value, c0 + 16'd6);
    hold(4);

    // R6: flag survives until cleared
    check(cap_flag == 1'b1, "R6 sticky", {15'd0, cap_flag}, 16'd1);

    // R2: filtered falling edge, six-edge latency
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0); hold(8); clear_flag();
    c0 = cnt;
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check(cap_flag == 1'b0, "R2 early", {15'd0, cap_flag}, 16'd0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check(cap_flag == 1'b1, "R2 flag", {15'd0, cap_flag}, 16'd1);
    check(cap_value == c0 + 16'd18, "R2 value", cap_value, c0 + 16'd18);
    hold(4); clear_flag();

    // R3: short pulses rejected by filter
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0); hold(8);
    for (int w = 1; w <= 3; w++) begin
      for (int i = 0; i < w; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
      check(cap_flag == 1'b0, "R3 filtered pulse", {15'd0, cap_flag}, 16'd0);
    end
    // R3: one-cycle pulse captures when unfiltered
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0); hold(3);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0); hold(0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    check(cap_flag == 1'b1, "R3 raw pulse", {15'd0, cap_flag}, 16'd1);
    clear_flag();

    // R4: falling edge ignored when rising selected
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0); hold(5); clear_flag();
    c0 = cap_value;
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check(cap_flag == 1'b0, "R4 wrong edge", {15'd0, cap_flag}, 16'd0);
    check(cap_value == c0, "R4 value kept", cap_value, c0);

    // R8: polarity toggles on a steady pin
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0); step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0); hold(3);
    check(cap_flag == 1'b0, "R8 polarity", {15'd0, cap_flag}, 16'd0);
    // R8: filter switched off while raw and filtered levels differ
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0); hold(8);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0); step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0); hold(5);
    check(cap_flag == 1'b0, "R8 filter switch", {15'd0, cap_flag}, 16'd0);

    // R6: clear on the capture edge keeps the flag
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0); hold(4);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0); step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    check(cap_flag == 1'b1, "R6 clear vs capture", {15'd0, cap_flag}, 16'd1);

    // random phase
    for (int blk = 0; blk < 600; blk++) begin
      logic p, er, fe, ie;
      int len;
      p  = 1'($urandom_range(1, 0));
      er = ($urandom_range(9, 0) == 0) ? ~cur_er : cur_er;
      fe = ($urandom_range(9, 0) == 0) ? ~cur_fe : cur_fe;
      ie = 1'($urandom_range(1, 0));
      len = $urandom_range(8, 1);
      for (int i = 0; i < len; i++)
        step(p, er, fe, ie, ($urandom_range(7, 0) == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule